// File: doc/BRIEF.md
# Operand-Wait Station for One Execution Unit

This block sits in front of a single execution unit in an out-of-order core. Decode writes an instruction into one of a few slots. Each of the two source operands arrives either as a value or as the tag of the instruction that will produce it. When an operand arrives as a tag, the slot waits.

A shared completion bus carries one (tag, value) pair per cycle to every slot at once. Each slot compares the bus tag with the tags it is waiting on. On a match it swaps the tag for the value and marks the operand as held. There is no central tracking table.

A slot that holds both operands is ready. The lowest-numbered ready slot is handed to the unit. It is released on the same clock edge that hands it over, so it can be reused at once. The unit always accepts.

Top module: `rsv_station`

## Requirements
- R1: After reset, no slot is occupied, `issue_valid` is 0 and `alloc_full` is 0.
- R2: When `alloc_valid` is 1 and `alloc_full` is 0, the instruction is written into a free slot on that clock edge. It stays there until it is issued.
- R3: `alloc_full` is 1 exactly when every slot is occupied. While it is 1, `alloc_valid` has no effect: nothing is stored and nothing is later issued from that request.
- R4: Each operand is a held flag plus one DATA_W-bit field. With the flag at 0, the low TAG_W bits of the field are the producer tag. With the flag at 1, the field is the operand value.
- R5: When `bus_valid` is 1, every occupied slot whose waiting operand tag equals `bus_tag` takes `bus_data` into that operand and sets its held flag on the same edge. Both operands of one slot may match at once.
- R6: A bus cycle with `bus_valid` at 0, or with a tag that no waiting operand carries, changes no slot.
- R7: If an operand written at allocation is waiting on the very tag that the bus carries in that same cycle, the operand is stored as already held, with the bus value.
- R8: A slot is issued only when both operands are held. At most one slot issues per cycle. When several are ready, the lowest slot index goes first. Slots are allocated lowest free index first.
- R9: While `issue_valid` is 1, the issue outputs carry the chosen slot's operation code, both operand values and destination tag. That slot is freed on the same edge.
- R10: `issue_valid` is a function of stored state only. A slot made ready on a clock edge is offered to the unit in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode offers an instruction |
| alloc_op | input | OP_W (4) | Operation code |
| alloc_a_held | input | 1 | Operand A is a value (1) or a tag (0) |
| alloc_a_field | input | DATA_W (16) | Operand A value or tag (low bits) |
| alloc_b_held | input | 1 | Operand B is a value (1) or a tag (0) |
| alloc_b_field | input | DATA_W (16) | Operand B value or tag (low bits) |
| alloc_dest_tag | input | TAG_W (4) | Tag this instruction will broadcast |
| alloc_full | output | 1 | No free slot; allocation refused |
| bus_valid | input | 1 | Completion bus carries a result |
| bus_tag | input | TAG_W (4) | Tag of the result |
| bus_data | input | DATA_W (16) | Result value |
| issue_valid | output | 1 | A slot is handed to the unit |
| issue_op | output | OP_W (4) | Operation code of issued slot |
| issue_a | output | DATA_W (16) | Operand A value |
| issue_b | output | DATA_W (16) | Operand B value |
| issue_dest_tag | output | TAG_W (4) | Destination tag of issued slot |

## Verification
Allocation, bus capture and release all take effect on the edge where their inputs are sampled. `issue_valid`, the issue fields and `alloc_full` are decoded from slot state alone. So each result is due one edge after its stimulus: an instruction allocated with both operands held, or completed by a bus capture, is offered in the next cycle, and a full station reports `alloc_full` right after the edge that filled its last slot. Every directed task drives its inputs shortly after a rising edge, waits for exactly one edge per stimulus, and compares the outputs a few nanoseconds later. A burst of simultaneous wake-ups is read out one slot per cycle, in index order.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  parameter int TAG_W  = 4;
  parameter int DATA_W = 16;
  parameter int OP_W   = 4;

  // operand: held flag plus a field that is a tag (low bits) or a value
  typedef struct packed {
    logic              held;
    logic [DATA_W-1:0] field;
  } opnd_t;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    opnd_t            a;
    opnd_t            b;
    logic [TAG_W-1:0] dest;
  } slot_t;

  function automatic logic tag_hit(opnd_t o, logic bv, logic [TAG_W-1:0] bt);
    return !o.held && bv && (o.field[TAG_W-1:0] == bt);
  endfunction

  function automatic opnd_t snoop(opnd_t o, logic bv, logic [TAG_W-1:0] bt,
                                  logic [DATA_W-1:0] bd);
    opnd_t r;
    r = o;
    if (tag_hit(o, bv, bt)) begin
      r.held  = 1'b1;
      r.field = bd;
    end
    return r;
  endfunction
endpackage

// File: rtl/rsv_pick.sv
module rsv_pick #(
  parameter int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsv_entry.sv
module rsv_entry
  import rsv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  slot_t             load_slot,
  input  logic              release_i,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              busy,
  output logic              ready,
  output slot_t             slot_q,
  output logic              hit_a,
  output logic              hit_b
);
  assign hit_a = busy && tag_hit(slot_q.a, bus_valid, bus_tag);
  assign hit_b = busy && tag_hit(slot_q.b, bus_valid, bus_tag);
  assign ready = busy && slot_q.a.held && slot_q.b.held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot_q <= '0;
    end else if (load) begin
      busy        <= 1'b1;
      slot_q.op   <= load_slot.op;
      slot_q.dest <= load_slot.dest;
      slot_q.a    <= snoop(load_slot.a, bus_valid, bus_tag, bus_data);
      slot_q.b    <= snoop(load_slot.b, bus_valid, bus_tag, bus_data);
    end else if (release_i) begin
      busy <= 1'b0;
    end else if (busy) begin
      slot_q.a <= snoop(slot_q.a, bus_valid, bus_tag, bus_data);
      slot_q.b <= snoop(slot_q.b, bus_valid, bus_tag, bus_data);
    end
  end
endmodule

// File: rtl/rsv_station.sv
module rsv_station
  import rsv_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [OP_W-1:0]   alloc_op,
  input  logic              alloc_a_held,
  input  logic [DATA_W-1:0] alloc_a_field,
  input  logic              alloc_b_held,
  input  logic [DATA_W-1:0] alloc_b_field,
  input  logic [TAG_W-1:0]  alloc_dest_tag,
  output logic              alloc_full,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              issue_valid,
  output logic [OP_W-1:0]   issue_op,
  output logic [DATA_W-1:0] issue_a,
  output logic [DATA_W-1:0] issue_b,
  output logic [TAG_W-1:0]  issue_dest_tag
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  // named internal events
  logic [NUM_ENTRIES-1:0] busy_vec, ready_vec, load_vec;
  logic [NUM_ENTRIES-1:0] alloc_grant, issue_grant;
  logic [NUM_ENTRIES-1:0] hit_a_vec, hit_b_vec, a_held_vec, b_held_vec;
  logic [IDX_W-1:0]       alloc_idx, issue_idx;
  logic                   free_any;
  logic                   alloc_take;
  slot_t                  new_slot;
  slot_t                  slots [NUM_ENTRIES];

  assign new_slot.op      = alloc_op;
  assign new_slot.dest    = alloc_dest_tag;
  assign new_slot.a.held  = alloc_a_held;
  assign new_slot.a.field = alloc_a_field;
  assign new_slot.b.held  = alloc_b_held;
  assign new_slot.b.field = alloc_b_field;

  rsv_pick #(.N(NUM_ENTRIES)) u_free_pick (
    .req(~busy_vec), .grant(alloc_grant), .idx(alloc_idx), .any(free_any)
  );

  rsv_pick #(.N(NUM_ENTRIES)) u_issue_pick (
    .req(ready_vec), .grant(issue_grant), .idx(issue_idx), .any(issue_valid)
  );

  assign alloc_full = !free_any;
  assign alloc_take = alloc_valid && free_any;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    assign load_vec[g] = alloc_take && alloc_grant[g];
    rsv_entry u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_vec[g]),
      .load_slot (new_slot),
      .release_i (issue_grant[g]),
      .bus_valid (bus_valid),
      .bus_tag   (bus_tag),
      .bus_data  (bus_data),
      .busy      (busy_vec[g]),
      .ready     (ready_vec[g]),
      .slot_q    (slots[g]),
      .hit_a     (hit_a_vec[g]),
      .hit_b     (hit_b_vec[g])
    );
    assign a_held_vec[g] = slots[g].a.held;
    assign b_held_vec[g] = slots[g].b.held;
  end

  always_comb begin
    issue_op       = slots[issue_idx].op;
    issue_a        = slots[issue_idx].a.field;
    issue_b        = slots[issue_idx].b.field;
    issue_dest_tag = slots[issue_idx].dest;
  end
endmodule

// File: rtl/rsv_station_chk.sv
module rsv_station_chk #(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   alloc_valid,
  input logic                   alloc_full,
  input logic                   issue_valid,
  input logic [IDX_W-1:0]       issue_idx,
  input logic [NUM_ENTRIES-1:0] busy_vec,
  input logic [NUM_ENTRIES-1:0] ready_vec,
  input logic [NUM_ENTRIES-1:0] issue_grant,
  input logic [NUM_ENTRIES-1:0] hit_a_vec,
  input logic [NUM_ENTRIES-1:0] hit_b_vec,
  input logic [NUM_ENTRIES-1:0] a_held_vec,
  input logic [NUM_ENTRIES-1:0] b_held_vec
);
  logic [NUM_ENTRIES-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (i < int'(issue_idx)) below_mask[i] = 1'b1;
  end

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_grant)); // R8

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ((ready_vec & below_mask) == '0)); // R8

  AST_ISSUE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !busy_vec[$past(issue_idx)]); // R9

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_full && !issue_valid) |=> (busy_vec == $past(busy_vec))); // R3

  AST_ALLOC_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_full) |=>
      ($countones(busy_vec) == $past($countones(busy_vec)) + 1 - int'($past(issue_valid)))); // R2

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cap
    AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
      hit_a_vec[g] |=> a_held_vec[g]); // R5
    AST_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
      hit_b_vec[g] |=> b_held_vec[g]); // R5
  end
endmodule

bind rsv_station rsv_station_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_full(alloc_full),
  .issue_valid(issue_valid), .issue_idx(issue_idx), .busy_vec(busy_vec),
  .ready_vec(ready_vec), .issue_grant(issue_grant), .hit_a_vec(hit_a_vec),
  .hit_b_vec(hit_b_vec), .a_held_vec(a_held_vec), .b_held_vec(b_held_vec)
);

// File: tb/test_rsv_station.sv
module test_rsv_station;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [3:0]  alloc_op = '0;
  logic        alloc_a_held = 1'b0;
  logic [15:0] alloc_a_field = '0;
  logic        alloc_b_held = 1'b0;
  logic [15:0] alloc_b_field = '0;
  logic [3:0]  alloc_dest_tag = '0;
  logic        alloc_full;
  logic        bus_valid = 1'b0;
  logic [3:0]  bus_tag = '0;
  logic [15:0] bus_data = '0;
  logic        issue_valid;
  logic [3:0]  issue_op;
  logic [15:0] issue_a, issue_b;
  logic [3:0]  issue_dest_tag;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk; // 125 MHz

  rsv_station i_rsv_station (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_alloc(logic [3:0] op, logic ah, logic [15:0] af,
                           logic bh, logic [15:0] bf, logic [3:0] dest);
    alloc_valid = 1'b1; alloc_op = op; alloc_a_held = ah; alloc_a_field = af;
    alloc_b_held = bh; alloc_b_field = bf; alloc_dest_tag = dest;
  endtask

  task automatic idle();
    alloc_valid = 1'b0;
    bus_valid   = 1'b0;
  endtask

  task automatic bcast(logic [3:0] t, logic [15:0] d);
    bus_valid = 1'b1; bus_tag = t; bus_data = d;
    tick();
    idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 issue_valid", issue_valid, 0);
    chk("R1 alloc_full", alloc_full, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 issue_valid after release", issue_valid, 0);
  endtask

  task automatic t_ready_alloc();
    set_alloc(4'd5, 1'b1, 16'h1234, 1'b1, 16'h00ab, 4'd6);
    tick(); idle();
    chk("R10 issue next cycle", issue_valid, 1);
    chk("R9 op", issue_op, 5);
    chk("R9 a", issue_a, 16'h1234);
    chk("R9 b", issue_b, 16'h00ab);
    chk("R9 dest", issue_dest_tag, 6);
    tick();
    chk("R9 slot freed", issue_valid, 0);
  endtask

  task automatic t_wakeup();
    set_alloc(4'd2, 1'b0, 16'd3, 1'b0, 16'd5, 4'd2);
    tick(); idle();
    chk("R4 waiting slot not issued", issue_valid, 0);
    bcast(4'd7, 16'hdead);
    chk("R6 other tag no effect", issue_valid, 0);
    bus_tag = 4'd3; bus_data = 16'hbeef; bus_valid = 1'b0;
    tick();
    chk("R6 bus_valid low no effect", issue_valid, 0);
    bcast(4'd3, 16'h1111);
    chk("R8 one operand only", issue_valid, 0);
    bcast(4'd5, 16'h2222);
    chk("R5 wakes after last operand", issue_valid, 1);
    chk("R5 a captured", issue_a, 16'h1111);
    chk("R5 b captured", issue_b, 16'h2222);
    chk("R9 dest", issue_dest_tag, 2);
    tick();
    chk("R9 freed", issue_valid, 0);
  endtask

  task automatic t_same_tag_both();
    set_alloc(4'd9, 1'b0, 16'd12, 1'b0, 16'd12, 4'd8);
    tick(); idle();
    bcast(4'd12, 16'h5a5a);
    chk("R5 both operands one bus cycle", issue_valid, 1);
    chk("R5 a", issue_a, 16'h5a5a);
    chk("R5 b", issue_b, 16'h5a5a);
    tick();
  endtask

  task automatic t_alloc_capture();
    set_alloc(4'd1, 1'b0, 16'd9, 1'b1, 16'h0042, 4'd4);
    bus_valid = 1'b1; bus_tag = 4'd9; bus_data = 16'h0abc;
    tick(); idle();
    chk("R7 captured at allocation", issue_valid, 1);
    chk("R7 a value", issue_a, 16'h0abc);
    chk("R7 b value", issue_b, 16'h0042);
    tick();
  endtask

  task automatic t_full();
    for (int k = 0; k < 4; k++) begin
      chk("R3 not full yet", alloc_full, 0);
      set_alloc(4'(k), 1'b0, 16'd1, 1'b0, 16'd1, 4'(10 + k));
      tick(); idle();
    end
    chk("R3 full", alloc_full, 1);
    set_alloc(4'd15, 1'b1, 16'h9999, 1'b1, 16'h9999, 4'd15);
    tick(); idle();
    chk("R3 still full", alloc_full, 1);
    chk("R3 refused request not issued", issue_valid, 0);
    bcast(4'd1, 16'h0777);
    for (int k = 0; k < 4; k++) begin
      chk("R8 burst issue", issue_valid, 1);
      chk("R8 lowest index order", issue_dest_tag, 32'(10 + k));
      chk("R8 op", issue_op, 32'(k));
      chk("R5 value", issue_a, 16'h0777);
      chk("R3 full tracks occupancy", alloc_full, (k == 0) ? 1 : 0);
      tick();
    end
    chk("R3 refused request never stored", issue_valid, 0);
    chk("R3 empty again", alloc_full, 0);
  endtask

  task automatic t_out_of_order();
    set_alloc(4'd0, 1'b0, 16'd4, 1'b1, 16'h0001, 4'd0); tick();
    set_alloc(4'd1, 1'b0, 16'd5, 1'b1, 16'h0002, 4'd1); tick();
    set_alloc(4'd2, 1'b1, 16'h0003, 1'b0, 16'd6, 4'd2); tick();
    idle();
    chk("R2 nothing ready", issue_valid, 0);
    bcast(4'd6, 16'h0066);
    chk("R8 youngest ready issues first", issue_dest_tag, 2);
    chk("R8 valid", issue_valid, 1);
    chk("R5 b of slot2", issue_b, 16'h0066);
    tick();
    chk("R9 freed", issue_valid, 0);
    bcast(4'd5, 16'h0055);
    chk("R8 middle slot", issue_dest_tag, 1);
    chk("R5 a of slot1", issue_a, 16'h0055);
    tick();
    // refill slot1 while slot0 waits: lowest free index is 1
    set_alloc(4'd7, 1'b1, 16'h0aaa, 1'b1, 16'h0bbb, 4'd7);
    bus_valid = 1'b1; bus_tag = 4'd4; bus_data = 16'h0044;
    tick(); idle();
    chk("R8 two ready, lowest first", issue_dest_tag, 0);
    chk("R5 a of slot0", issue_a, 16'h0044);
    tick();
    chk("R2 refilled slot issues next", issue_dest_tag, 7);
    chk("R2 refilled a", issue_a, 16'h0aaa);
    tick();
    chk("R9 all drained", issue_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ready_alloc();
    t_wakeup();
    t_same_tag_both();
    t_alloc_capture();
    t_full();
    t_out_of_order();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule